// File: doc/BRIEF.md
# Dual Endpoint Buffer Access Window

This block lets a microcontroller reach two small endpoint data buffers through one byte-wide data register. A control register holds a one-bit selector that picks the buffer. The data register, called the window, always reaches the selected buffer at the position given by a pointer. Every accepted access to the window moves that pointer forward by one. The pointer is three bits wide and wraps, so eight consecutive accesses walk through a whole buffer and return to the start.

Both buffers share the same pointer. Software can set the pointer back to zero by writing a self-clearing bit in the control register. A receive-block input from the surrounding endpoint logic protects buffer 0: while it is high, writes aimed at buffer 0 are dropped. Moving packets between the buffers and the bus, and the endpoint handshakes, are handled elsewhere.

Top module: `epbuf_window`

## Requirements
- R1: After reset the pointer is 0 and the selector is 0. Every byte of both buffers reads as 00h.
- R2: A write strobe at the window offset (05h) stores the write data into the selected buffer at the pointer position, and the pointer then advances by one.
- R3: While the address is 05h, read data shows the selected buffer's byte at the current pointer in the same cycle. A read strobe advances the pointer at the clock edge that ends that cycle.
- R4: The pointer is a 3-bit counter that wraps from 7 back to 0.
- R5: Writing the control offset (06h) with bit 1 set returns the pointer to 0.
- R6: A write to the control offset loads bit 0 of the write data into the selector, where 0 selects buffer 0 and 1 selects buffer 1. Reading offset 06h returns the selector in bit 0 and 0 in every other bit, so bit 1 never reads back as 1.
- R7: While receive-block is high, a write to the window with the selector at 0 leaves buffer 0 unchanged and does not move the pointer. While receive-block is low, the same write is stored.
- R8: Changing the selector without bit 1 set leaves the pointer where it was.
- R9: Reads at any other offset return 00h. Writes at any other offset change neither the buffers, the selector nor the pointer.
- R10: A read strobe and a write strobe together at the window count as a single access. The write is stored if it is allowed, the read data shows the old byte, and the pointer advances by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 8 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe, one access per cycle it is high |
| bus_wr | input | 1 | Write strobe, one access per cycle it is high |
| rx_block | input | 1 | When high, writes into buffer 0 are refused |
| bus_rdata | output | 8 | Read data for the current offset (combinational) |

## Verification
The bench walks the pointer past 7 in both buffers. A counter without the wrap, or one wider than three bits, would show the wrong byte on the ninth access. It writes buffer 0 while receive-block is high and then reads the buffer back. A design that stored the byte, or that advanced the pointer anyway, returns data from the wrong position. It also switches the selector in the middle of a buffer, clears the pointer through the control register, reads that register back and issues combined read and write strobes. These steps catch a pointer that resets when the selector changes, a reset bit that sticks, and a combined access that counts twice.

// File: rtl/epbuf_pkg.sv
// Package: shared constants for the endpoint buffer access window.
// Assumes: a single selector bit, so exactly two buffers.
package epbuf_pkg;
    localparam int NUM_BUF = 2;   // buffers behind the window
    localparam int SEL_BIT = 0;   // control bit: buffer selector
    localparam int CLR_BIT = 1;   // control bit: pointer clear, write-only
endpackage

// File: rtl/epbuf_ptr.sv
// Module: wrapping access pointer shared by both buffers.
// Assumes: clear and step never need to combine; clear wins if both occur.
module epbuf_ptr #(
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             clear,
    output logic [PTR_W-1:0] ptr
);
    // Counter: clear, else step with natural wrap at DEPTH (power of two).
    always_ff @(posedge clk) begin
        if (!rst_n)     ptr <= '0;
        else if (clear) ptr <= '0;
        else if (step)  ptr <= ptr + 1'b1;
    end
endmodule

// File: rtl/epbuf_store.sv
// Module: one byte buffer with a single write port and an asynchronous read.
// Assumes: DEPTH is a power of two so the pointer covers it exactly.
module epbuf_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [PTR_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Storage: clear every entry on reset, write one entry when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[idx] <= wdata;
        end
    end

    // Read port: byte at the pointer.
    always_comb rdata = mem[idx];
endmodule

// File: rtl/epbuf_decode.sv
// Module: turns bus strobes into buffer writes, pointer steps and control writes.
// Assumes: one access per cycle; read and write together count once.
module epbuf_decode #(
    parameter int          ADDR_W    = 8,
    parameter int          DATA_W    = 8,
    parameter logic [7:0]  WIN_ADDR  = 8'h05,
    parameter logic [7:0]  CTRL_ADDR = 8'h06
) (
    input  logic                        bus_rd,
    input  logic                        bus_wr,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [DATA_W-1:0]           bus_wdata,
    input  logic                        rx_block,
    input  logic                        sel,
    output logic [epbuf_pkg::NUM_BUF-1:0] buf_we,
    output logic                        ptr_step,
    output logic                        ptr_clear,
    output logic                        ctrl_we,
    output logic                        hit_win,
    output logic                        hit_ctrl
);
    import epbuf_pkg::*;
    logic wr_ok;

    // Decode: address match, write permission and pointer step.
    always_comb begin
        hit_win   = (bus_addr == ADDR_W'(WIN_ADDR));
        hit_ctrl  = (bus_addr == ADDR_W'(CTRL_ADDR));
        wr_ok     = bus_wr && hit_win && (sel || !rx_block);
        buf_we    = '0;
        buf_we[sel] = wr_ok;
        ptr_step  = wr_ok || (bus_rd && hit_win);
        ctrl_we   = bus_wr && hit_ctrl;
        ptr_clear = ctrl_we && bus_wdata[CLR_BIT];
    end
endmodule

// File: rtl/epbuf_window.sv
// Module: top of the endpoint buffer access window.
// Holds the selector, two buffers and the shared pointer, and muxes read data.
// Assumes: synchronous active-low reset; read data is combinational.
module epbuf_window #(
    parameter int         ADDR_W    = 8,
    parameter int         DATA_W    = 8,
    parameter int         DEPTH     = 8,
    parameter logic [7:0] WIN_ADDR  = 8'h05,
    parameter logic [7:0] CTRL_ADDR = 8'h06
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic              rx_block,
    output logic [DATA_W-1:0] bus_rdata
);
    import epbuf_pkg::*;
    localparam int PTR_W = $clog2(DEPTH);

    logic                sel_q;
    logic [PTR_W-1:0]    ptr_q;
    logic [NUM_BUF-1:0]  buf_we;
    logic                ptr_step, ptr_clear, ctrl_we, hit_win, hit_ctrl;
    logic [DATA_W-1:0]   buf_rd [NUM_BUF];

    epbuf_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .WIN_ADDR(WIN_ADDR), .CTRL_ADDR(CTRL_ADDR)
    ) u_dec (
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .rx_block(rx_block), .sel(sel_q),
        .buf_we(buf_we), .ptr_step(ptr_step), .ptr_clear(ptr_clear),
        .ctrl_we(ctrl_we), .hit_win(hit_win), .hit_ctrl(hit_ctrl)
    );

    epbuf_ptr #(.DEPTH(DEPTH)) u_ptr (
        .clk(clk), .rst_n(rst_n), .step(ptr_step),
        .clear(ptr_clear), .ptr(ptr_q)
    );

    for (genvar b = 0; b < NUM_BUF; b++) begin : g_buf
        epbuf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
            .clk(clk), .rst_n(rst_n), .we(buf_we[b]), .idx(ptr_q),
            .wdata(bus_wdata), .rdata(buf_rd[b])
        );
    end

    // Selector register: loaded by a control write.
    always_ff @(posedge clk) begin
        if (!rst_n)       sel_q <= 1'b0;
        else if (ctrl_we) sel_q <= bus_wdata[SEL_BIT];
    end

    // Read mux: window byte, control view with clear bit always 0, else zero.
    always_comb begin
        bus_rdata = '0;
        if (hit_win)       bus_rdata = buf_rd[sel_q];
        else if (hit_ctrl) bus_rdata[SEL_BIT] = sel_q;
    end
endmodule

// File: rtl/epbuf_window_chk.sv
// Module: assertion checker for epbuf_window, attached by bind below.
// Assumes: it sees the pointer and selector state of the top module.
module epbuf_window_chk #(
    parameter int         ADDR_W    = 8,
    parameter int         DATA_W    = 8,
    parameter int         PTR_W     = 3,
    parameter logic [7:0] WIN_ADDR  = 8'h05,
    parameter logic [7:0] CTRL_ADDR = 8'h06
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic              rx_block,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [PTR_W-1:0]  ptr,
    input logic              sel
);
    logic at_win, at_ctrl;
    always_comb begin
        at_win  = (bus_addr == ADDR_W'(WIN_ADDR));
        at_ctrl = (bus_addr == ADDR_W'(CTRL_ADDR));
    end

    AST_READ_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (at_win && bus_rd) |=> ptr == PTR_W'($past(ptr) + 1'b1));          // R3
    AST_BLOCKED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (at_win && bus_wr && !bus_rd && !sel && rx_block) |=> $stable(ptr)); // R7
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (at_ctrl && bus_wr && bus_wdata[1]) |=> ptr == '0);                 // R5
    AST_SEL_KEEPS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        (at_ctrl && bus_wr && !bus_wdata[1]) |=> $stable(ptr));             // R8
    AST_CTRL_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
        (at_ctrl && bus_wr) |=> (at_ctrl |-> (bus_rdata[0] == $past(bus_wdata[0])
                                              && bus_rdata[1] == 1'b0)));    // R6
    AST_OTHER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!at_win && !at_ctrl) |=> $stable(ptr) && $stable(sel));           // R9
endmodule

bind epbuf_window epbuf_window_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PTR_W(PTR_W),
    .WIN_ADDR(WIN_ADDR), .CTRL_ADDR(CTRL_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .rx_block(rx_block),
    .bus_rdata(bus_rdata), .ptr(ptr_q), .sel(sel_q)
);

// File: tb/epbuf_window_test.sv
// Bench: behavioural reference model compared with read data every cycle.
module epbuf_window_test;
    logic       clk = 0;
    logic       rst_n = 0;
    logic [7:0] bus_addr = 0, bus_wdata = 0, bus_rdata;
    logic       bus_rd = 0, bus_wr = 0, rx_block = 0;

    int errors = 0, checks = 0;
    bit done = 0;
    int         m_ptr;
    bit         m_sel;
    logic [7:0] m_mem [2][8];

    epbuf_window uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .rx_block(rx_block),
        .bus_rdata(bus_rdata)
    );

    always #4 clk = ~clk;

    function automatic logic [7:0] expect_rd(logic [7:0] a);
        if (a == 8'h05) return m_mem[m_sel][m_ptr];
        if (a == 8'h06) return {7'b0, m_sel};
        return 8'h00;
    endfunction

    // One bus cycle: drive at negedge, compare before edge, update model after.
    task automatic access(input logic [7:0] a, input logic [7:0] d,
                          input bit rd, input bit wr, input bit blk,
                          input string tag);
        logic [7:0] exp;
        bit acc;
        bus_addr = a; bus_wdata = d; bus_rd = rd; bus_wr = wr; rx_block = blk;
        #2;
        exp = expect_rd(a);
        checks++;
        if (bus_rdata !== exp) begin
            errors++;
            $display("FAIL %s addr=%02h actual=%02h expected=%02h", tag, a, bus_rdata, exp);
        end
        @(posedge clk);
        if (wr && a == 8'h06) begin
            m_sel = d[0];
            if (d[1]) m_ptr = 0;
        end else if (a == 8'h05) begin
            acc = rd;
            if (wr && (m_sel || !blk)) begin
                m_mem[m_sel][m_ptr] = d;
                acc = 1;
            end
            if (acc) m_ptr = (m_ptr + 1) % 8;
        end
        @(negedge clk);
        bus_rd = 0; bus_wr = 0;
    endtask

    initial begin
        m_ptr = 0; m_sel = 0;
        for (int b = 0; b < 2; b++) for (int i = 0; i < 8; i++) m_mem[b][i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset values, buffer 0 all zero; nine reads cover R4 wrap
        for (int i = 0; i < 9; i++) access(8'h05, 0, 1, 0, 0, "R1");
        access(8'h06, 0, 0, 0, 0, "R6");
        // R6: select buffer 1, pointer stays (R8)
        access(8'h06, 8'h01, 0, 1, 0, "R6");
        access(8'h06, 0, 0, 0, 0, "R6");
        for (int i = 0; i < 8; i++) access(8'h05, 0, 1, 0, 0, "R1");
        // R2: fill buffer 1 with ten bytes, wrapping (R4)
        for (int i = 0; i < 10; i++) access(8'h05, 8'hA0 + 8'(i), 0, 1, 0, "R2");
        for (int i = 0; i < 9; i++) access(8'h05, 0, 1, 0, 0, "R3");
        // R5: clear pointer with select kept at 1; clear bit reads 0 (R6)
        access(8'h06, 8'h03, 0, 1, 0, "R5");
        access(8'h06, 0, 0, 0, 0, "R6");
        access(8'h05, 0, 1, 0, 0, "R5");
        access(8'h05, 0, 1, 0, 0, "R4");
        // R8: switch to buffer 0 mid-buffer, pointer unchanged
        access(8'h06, 8'h00, 0, 1, 0, "R8");
        access(8'h05, 0, 1, 0, 0, "R8");
        // R7: blocked writes to buffer 0, then allowed writes
        access(8'h05, 8'h5A, 0, 1, 1, "R7");
        access(8'h05, 8'h5B, 0, 1, 1, "R7");
        access(8'h05, 8'h33, 0, 1, 0, "R7");
        access(8'h06, 8'h02, 0, 1, 0, "R5");
        for (int i = 0; i < 8; i++) access(8'h05, 0, 1, 0, 0, "R7");
        // R9: other offsets read zero and change nothing
        access(8'h07, 8'hFF, 0, 1, 0, "R9");
        access(8'h00, 8'h03, 0, 1, 0, "R9");
        access(8'h04, 0, 1, 0, 0, "R9");
        access(8'h06, 0, 0, 0, 0, "R9");
        access(8'h05, 0, 1, 0, 0, "R9");
        // R10: combined read and write count once; also blocked variant
        access(8'h05, 8'hC1, 1, 1, 0, "R10");
        access(8'h05, 8'hC2, 1, 1, 1, "R10");
        access(8'h06, 8'h02, 0, 1, 0, "R10");
        for (int i = 0; i < 4; i++) access(8'h05, 0, 1, 0, 0, "R10");
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule